// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit gathers the four interrupt causes of a serial port into one interrupt request and a readable identification byte. The four causes are a line error or break, received data available, transmit holding register empty, and a modem status change. The datapath that detects these conditions is outside the unit. It only delivers a one-cycle pulse for each condition.

Each cause is latched as pending when its pulse arrives. A cause is reported only while its bit in a software-written enable byte is set. When several enabled causes are pending, the identification byte shows the one with the highest priority.

Each pending cause is cleared by the register access that services it:
- reading the line status register clears a line error;
- reading the receive data register clears received data;
- writing the transmit holding register clears transmit empty;
- reading the modem status register clears a modem change;
- reading the identification byte also clears transmit empty, but only while that cause is the one being reported.

Top module: `sirq_ident`

## Requirements
- R1: After reset the enable byte reads 0x00, nothing is pending, `irq` is 0 and `ident` reads 0x01.
- R2: A write to the enable byte keeps bits 3:0 and `en_rdata` bits 7:4 always read 0. Bit 0 enables received data, bit 1 transmit empty, bit 2 line error, bit 3 modem change.
- R3: `ident` bits 2:1 name the reported cause as 11 line error, 10 received data, 01 transmit empty, 00 modem change. The priority runs from line error (highest) through received data and transmit empty to modem change (lowest).
- R4: `ident` bit 0 is 0 while any enabled cause is pending and 1 otherwise, `ident` bits 7:3 are 0, and `irq` is high exactly while an enabled cause is pending.
- R5: A cause whose enable bit is clear stays latched without raising `irq`. Setting its enable bit raises `irq` and reports the cause in the cycle after the write.
- R6: Reading the line status register (`rd_linestat`) clears a pending line error.
- R7: Reading the receive data register (`rd_rxdata`) clears pending received data.
- R8: Writing the transmit holding register (`wr_txhold`) clears pending transmit empty. Reading `ident` while it reports code 01 also clears it.
- R9: Reading the modem status register (`rd_modemstat`) clears a pending modem change.
- R10: Reading `ident` while it reports any cause other than transmit empty clears nothing.
- R11: A condition pulse in the same cycle as its own clear access leaves the cause pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the enable byte |
| en_wdata | input | 8 | Enable byte write data |
| en_rdata | output | 8 | Enable byte read value |
| line_err_set | input | 1 | Pulse: line error or break detected |
| rx_avail_set | input | 1 | Pulse: received byte available |
| tx_empty_set | input | 1 | Pulse: transmit holding register became empty |
| modem_chg_set | input | 1 | Pulse: modem status input changed |
| rd_linestat | input | 1 | Line status register read strobe |
| rd_rxdata | input | 1 | Receive data register read strobe |
| wr_txhold | input | 1 | Transmit holding register write strobe |
| rd_modemstat | input | 1 | Modem status register read strobe |
| rd_ident | input | 1 | Identification byte read strobe |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Pending flags and enable bits are registers, and `ident` and `irq` are decoded from them without further delay. Every pulse, strobe or enable write therefore shows its result on the outputs right after the one clock edge that samples it. The bench drives inputs at the falling edge and samples outputs at the following falling edge, which lies after exactly that one rising edge. It then releases the strobes, so every strobe covers exactly one edge.

// File: rtl/sirq_ident.sv
module sirq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  input  logic       line_err_set,
  input  logic       rx_avail_set,
  input  logic       tx_empty_set,
  input  logic       modem_chg_set,
  input  logic       rd_linestat,
  input  logic       rd_rxdata,
  input  logic       wr_txhold,
  input  logic       rd_modemstat,
  input  logic       rd_ident,
  output logic [7:0] ident,
  output logic       irq
);
  // bit order follows the enable byte: 0 rx, 1 tx, 2 line, 3 modem
  logic [3:0] en_q, pend_q, act, set_v, clr_v;
  logic [1:0] code;
  logic       tx_shown;

  assign act      = en_q & pend_q;
  assign irq      = |act;
  assign set_v    = {modem_chg_set, line_err_set, tx_empty_set, rx_avail_set};
  assign tx_shown = act[1] & ~act[2] & ~act[0];
  assign clr_v    = {rd_modemstat, rd_linestat, wr_txhold | (rd_ident & tx_shown), rd_rxdata};

  always_comb begin
    if (act[2])      code = 2'b11;
    else if (act[0]) code = 2'b10;
    else if (act[1]) code = 2'b01;
    else             code = 2'b00;
  end

  assign ident    = {5'b0, code, ~irq};
  assign en_rdata = {4'b0, en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= en_wdata[3:0];
      pend_q <= (pend_q & ~clr_v) | set_v;
    end
  end
endmodule

module sirq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr,
  input logic [7:0] en_wdata,
  input logic [7:0] en_rdata,
  input logic       line_err_set,
  input logic       rx_avail_set,
  input logic       tx_empty_set,
  input logic       modem_chg_set,
  input logic       rd_linestat,
  input logic       rd_rxdata,
  input logic       wr_txhold,
  input logic       rd_modemstat,
  input logic [7:0] ident,
  input logic       irq
);
  assert_enable_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata[7:4] == 4'b0);
  assert_ident_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ident[7:3] == 5'b0 && irq == !ident[0]);
  assert_disable_quiets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && en_wdata[3:0] == 4'b0 |=> !irq);
  assert_line_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_linestat && !line_err_set |=> !(ident[2:1] == 2'b11 && !ident[0]));
  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rxdata && !rx_avail_set |=> !(ident[2:1] == 2'b10 && !ident[0]));
  assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txhold && !tx_empty_set |=> !(ident[2:1] == 2'b01 && !ident[0]));
  assert_modem_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_modemstat && !modem_chg_set |=> !(ident[2:0] == 3'b000));
endmodule

bind sirq_ident sirq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
  .line_err_set(line_err_set), .rx_avail_set(rx_avail_set), .tx_empty_set(tx_empty_set),
  .modem_chg_set(modem_chg_set), .rd_linestat(rd_linestat), .rd_rxdata(rd_rxdata),
  .wr_txhold(wr_txhold), .rd_modemstat(rd_modemstat), .ident(ident), .irq(irq)
);

// File: tb/sirq_ident_test.sv
module sirq_ident_test;
  logic clk = 0, rst_n = 0;
  logic en_wr = 0;
  logic [7:0] en_wdata = 0;
  logic line_err_set = 0, rx_avail_set = 0, tx_empty_set = 0, modem_chg_set = 0;
  logic rd_linestat = 0, rd_rxdata = 0, wr_txhold = 0, rd_modemstat = 0, rd_ident = 0;
  logic [7:0] en_rdata, ident;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sirq_ident uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    en_wr = 0; line_err_set = 0; rx_avail_set = 0; tx_empty_set = 0; modem_chg_set = 0;
    rd_linestat = 0; rd_rxdata = 0; wr_txhold = 0; rd_modemstat = 0; rd_ident = 0;
  endtask

  task automatic wr_en(logic [7:0] v);
    en_wr = 1; en_wdata = v; step();
  endtask

  task automatic t_reset();
    chk("R1 ident", ident, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 enable", en_rdata, 8'h00);
  endtask

  task automatic t_enable_reg();
    wr_en(8'hFF);
    chk("R2 upper zero", en_rdata, 8'h0F);
    wr_en(8'hA5);
    chk("R2 stored", en_rdata, 8'h05);
  endtask

  task automatic t_priority();
    wr_en(8'h0F);
    line_err_set = 1; rx_avail_set = 1; tx_empty_set = 1; modem_chg_set = 1; step();
    chk("R3 line first", ident, 8'h06);
    chk("R4 irq high", {7'b0, irq}, 8'h01);
    rd_linestat = 1; step();
    chk("R6 line cleared", ident, 8'h04);
    rd_rxdata = 1; step();
    chk("R7 rx cleared", ident, 8'h02);
    rd_ident = 1; step();
    chk("R8 ident read clears tx", ident, 8'h00);
    rd_modemstat = 1; step();
    chk("R9 modem cleared", ident, 8'h01);
    chk("R4 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_tx_write();
    tx_empty_set = 1; step();
    chk("R3 tx code", ident, 8'h02);
    wr_txhold = 1; step();
    chk("R8 write clears tx", ident, 8'h01);
  endtask

  task automatic t_ident_noclear();
    tx_empty_set = 1; rx_avail_set = 1; step();
    chk("R3 rx over tx", ident, 8'h04);
    rd_ident = 1; step();
    chk("R10 no clear", ident, 8'h04);
    rd_rxdata = 1; step();
    chk("R10 tx kept", ident, 8'h02);
    modem_chg_set = 1; step();
    rd_ident = 1; step();
    chk("R8 tx cleared by ident", ident, 8'h00);
    rd_ident = 1; step();
    chk("R10 modem kept", ident, 8'h00);
    rd_modemstat = 1; step();
    chk("R9 modem cleared", ident, 8'h01);
  endtask

  task automatic t_disabled();
    wr_en(8'h00);
    rx_avail_set = 1; step();
    chk("R5 masked irq", {7'b0, irq}, 8'h00);
    chk("R5 masked ident", ident, 8'h01);
    wr_en(8'h01);
    chk("R5 late enable irq", {7'b0, irq}, 8'h01);
    chk("R5 late enable ident", ident, 8'h04);
    rd_rxdata = 1; step();
    chk("R7 cleared", ident, 8'h01);
  endtask

  task automatic t_collision();
    wr_en(8'h0F);
    rx_avail_set = 1; rd_rxdata = 1; step();
    chk("R11 set wins", ident, 8'h04);
    rd_rxdata = 1; step();
    chk("R11 cleared after", ident, 8'h01);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_enable_reg();
    t_priority();
    t_tx_write();
    t_ident_noclear();
    t_disabled();
    t_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule